// File: doc/BRIEF.md
# Fast PWM timer with buffered compare

This block is a 16-bit up-counting timer that makes single-slope PWM waveforms. On every cycle where the timer-clock enable `tick` is high, the counter moves one step. When it equals the selected TOP value it returns to zero on that same step. TOP can be one of three fixed values, giving 8-, 9- or 10-bit resolution. It can also be taken from compare register A, which is double-buffered, or from a capture register, which is not buffered.

Two compare channels watch the counter. Each channel drives a PWM output, and the output can be normal, inverted or held low. Sticky flags record the TOP restart, each compare match and the capture-as-TOP restart. Software reaches the block through a simple write port. Writing a 1 to a flag clears that flag.

The register map is as follows:
- Address 0 is control. `[2:0]` selects TOP, `[5:4]` is the channel A output mode and `[7:6]` is the channel B output mode.
- Address 1 is the compare A buffer.
- Address 2 is compare B.
- Address 3 is the capture register.
- Address 4 is the flag clear. Its bits line up with the `flags` output.

Writes to any other address have no effect.

Top module: `fpwm_timer`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) sets the counter, all registers, all flags and both PWM outputs to zero. After reset, TOP select 0 is in force.
- R2: The counter changes only on edges where `tick` is high. Below TOP it increments by one. Above TOP it increments, and 0xFFFF wraps to 0x0000.
- R3: TOP select codes are: 0 for 0x00FF, 1 for 0x01FF, 2 for 0x03FF, 3 for active compare A, and 4 for the capture register. Codes 5 to 7 act as 0. On a tick where the counter equals TOP, the counter becomes 0 and `flags[0]` (overflow) is set on that same edge.
- R4: With select 3, `flags[1]` (match A) is set on the same edge as `flags[0]` at the restart. With select 4, `flags[3]` (capture TOP) is set on the same edge as `flags[0]`. `flags[3]` is set by nothing else.
- R5: A write to address 1 changes only the buffer. The buffer value becomes the active compare A value only on the restart edge at TOP.
- R6: The capture register takes effect as soon as it is written. If it is written below the current count, the counter runs to 0xFFFF and wraps to 0 without setting `flags[0]`. It restarts only when it next equals the capture value.
- R7: On a tick where the counter equals a channel's active compare value, that channel's flag is set: `flags[1]` for A and `flags[2]` for B. A compare value above TOP never sets the flag.
- R8: While a fixed TOP (select 0, 1, 2, or 5 to 7) is in force, writes to the compare A buffer and to compare B have their bits above the resolution forced to zero.
- R9: Output mode 2 (non-inverted) drives the output to 1 on the restart edge and to 0 on a compare-match edge. If both fall on the same edge, the restart wins. For compare value C and TOP value T with C < T, the output is high for C+1 ticks out of every T+1. If C is greater than or equal to T, the output is always high.
- R10: Output mode 3 (inverted) drives the output to 0 on the restart edge and to 1 on a match edge, and the restart wins. For C < T the output is high for T−C ticks out of every T+1. If C is greater than or equal to T, the output is always low.
- R11: Output modes 0 and 1 hold the output at 0 from the edge after the mode is in force.
- R12: Flags stay set until cleared by a write of 1 to the matching bit at address 4. Bits written as 0 leave their flags alone. If a clear and a set land on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timer-clock enable; the counter steps on edges where this is high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| count | output | 16 | Current counter value |
| flags | output | 4 | Sticky flags: [0] overflow, [1] match A, [2] match B, [3] capture TOP |
| pwmA | output | 1 | Channel A PWM output |
| pwmB | output | 1 | Channel B PWM output |

## Verification
Two functions can fall on the same edge: a flag being set by the TOP restart, and software clearing that flag. The bench provokes this by holding the clear write for overflow on the edge where the counter sits at TOP. It passes only if the flag reads 1 afterwards, and a second clear with no set pending then reads 0. A second collision is a compare value equal to TOP, where restart and match coincide. It is judged by whether the PWM output stays high (mode 2) or stays low (mode 3) for the whole period.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

  localparam int CH_N   = 2;
  localparam int FLAG_N = CH_N + 2;

  localparam int ADR_CTL  = 0;
  localparam int ADR_BUFA = 1;
  localparam int ADR_CMPB = 2;
  localparam int ADR_CAP  = 3;
  localparam int ADR_CLR  = 4;

  typedef enum logic [2:0] {
    TOP_FIX8  = 3'd0,
    TOP_FIX9  = 3'd1,
    TOP_FIX10 = 3'd2,
    TOP_CMPA  = 3'd3,
    TOP_CAP   = 3'd4
  } topSel_e;

  typedef struct packed {
    logic            wrCtl;
    logic            wrBufA;
    logic            wrCmpB;
    logic            wrCap;
    logic            wrClr;
    logic            advance;
    logic            restart;
    logic            reloadA;
    logic [CH_N-1:0] chMatch;
    logic            setCap;
  } strobes_t;

endpackage

// File: rtl/fpwm_chan.sv
module fpwm_chan (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       restart,
  input  logic       match,
  output logic       pwm
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm <= 1'b0;
    end else if (!mode[1]) begin
      pwm <= 1'b0;
    end else if (restart) begin
      pwm <= ~mode[0];
    end else if (match) begin
      pwm <= mode[0];
    end
  end

endmodule

// File: rtl/fpwm_ctrl.sv
module fpwm_ctrl
  import fpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic                       tick,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [CNT_W-1:0]           count,
  input  logic [CNT_W-1:0]           topVal,
  input  logic [CH_N-1:0][CNT_W-1:0] cmpAct,
  input  logic                       capIsTop,
  output strobes_t                   stb
);

  logic            atTop;
  logic [CH_N-1:0] matchVec;

  assign atTop = (count == topVal);

  for (genvar i = 0; i < CH_N; i++) begin : g_match
    assign matchVec[i] = tick && (count == cmpAct[i]);
  end

  always_comb begin
    stb         = '0;
    stb.wrCtl   = wrEn && (wrAddr == ADDR_W'(ADR_CTL));
    stb.wrBufA  = wrEn && (wrAddr == ADDR_W'(ADR_BUFA));
    stb.wrCmpB  = wrEn && (wrAddr == ADDR_W'(ADR_CMPB));
    stb.wrCap   = wrEn && (wrAddr == ADDR_W'(ADR_CAP));
    stb.wrClr   = wrEn && (wrAddr == ADDR_W'(ADR_CLR));
    stb.advance = tick;
    stb.restart = tick && atTop;
    stb.reloadA = tick && atTop;
    stb.chMatch = matchVec;
    stb.setCap  = tick && atTop && capIsTop;
  end

endmodule

// File: rtl/fpwm_dp.sv
module fpwm_dp
  import fpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int RES_LO = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  strobes_t                   stb,
  input  logic [CNT_W-1:0]           wrData,
  output logic [CNT_W-1:0]           count,
  output logic [CNT_W-1:0]           topVal,
  output logic [CH_N-1:0][CNT_W-1:0] cmpAct,
  output logic                       capIsTop,
  output topSel_e                    topSel,
  output logic [CH_N-1:0][1:0]       chMode,
  output logic [FLAG_N-1:0]          flags,
  output logic [CH_N-1:0]            pwm
);

  localparam logic [CNT_W-1:0] FIX8  = CNT_W'((64'd1 << RES_LO) - 64'd1);
  localparam logic [CNT_W-1:0] FIX9  = CNT_W'((64'd1 << (RES_LO + 1)) - 64'd1);
  localparam logic [CNT_W-1:0] FIX10 = CNT_W'((64'd1 << (RES_LO + 2)) - 64'd1);

  logic [CNT_W-1:0]  bufA;
  logic [CNT_W-1:0]  capReg;
  logic [FLAG_N-1:0] flagSet;
  logic [FLAG_N-1:0] flagClr;

  function automatic logic [CNT_W-1:0] maskFor(input logic [CNT_W-1:0] d,
                                               input topSel_e sel);
    case (sel)
      TOP_CMPA, TOP_CAP: return d;
      TOP_FIX9:          return d & FIX9;
      TOP_FIX10:         return d & FIX10;
      default:           return d & FIX8;
    endcase
  endfunction

  function automatic topSel_e decodeSel(input logic [2:0] code);
    case (code)
      3'd1:    return TOP_FIX9;
      3'd2:    return TOP_FIX10;
      3'd3:    return TOP_CMPA;
      3'd4:    return TOP_CAP;
      default: return TOP_FIX8;
    endcase
  endfunction

  always_comb begin
    case (topSel)
      TOP_FIX9:  topVal = FIX9;
      TOP_FIX10: topVal = FIX10;
      TOP_CMPA:  topVal = cmpAct[0];
      TOP_CAP:   topVal = capReg;
      default:   topVal = FIX8;
    endcase
  end

  assign capIsTop = (topSel == TOP_CAP);
  assign flagSet  = {stb.setCap, stb.chMatch, stb.restart};
  assign flagClr  = stb.wrClr ? wrData[FLAG_N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      topSel <= TOP_FIX8;
      chMode <= '0;
      bufA   <= '0;
      cmpAct <= '0;
      capReg <= '0;
      flags  <= '0;
    end else begin
      if (stb.advance) begin
        count <= stb.restart ? '0 : count + 1'b1;
      end
      if (stb.wrCtl) begin
        topSel <= decodeSel(wrData[2:0]);
        for (int i = 0; i < CH_N; i++) begin
          chMode[i] <= wrData[4 + 2*i +: 2];
        end
      end
      if (stb.wrBufA) begin
        bufA <= maskFor(wrData, topSel);
      end
      if (stb.reloadA) begin
        cmpAct[0] <= bufA;
      end
      if (stb.wrCmpB) begin
        cmpAct[1] <= maskFor(wrData, topSel);
      end
      if (stb.wrCap) begin
        capReg <= wrData;
      end
      flags <= (flags & ~flagClr) | flagSet;
    end
  end

  for (genvar i = 0; i < CH_N; i++) begin : g_chan
    fpwm_chan u_chan (
      .clk     (clk),
      .rst     (rst),
      .mode    (chMode[i]),
      .restart (stb.restart),
      .match   (stb.chMatch[i]),
      .pwm     (pwm[i])
    );
  end

endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer
  import fpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int RES_LO = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  count,
  output logic [FLAG_N-1:0] flags,
  output logic              pwmA,
  output logic              pwmB
);

  strobes_t                   stb;
  logic [CNT_W-1:0]           topVal;
  logic [CH_N-1:0][CNT_W-1:0] cmpAct;
  logic                       capIsTop;
  topSel_e                    topSel;
  logic [CH_N-1:0][1:0]       chMode;
  logic [CH_N-1:0]            pwm;

  fpwm_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .tick     (tick),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .count    (count),
    .topVal   (topVal),
    .cmpAct   (cmpAct),
    .capIsTop (capIsTop),
    .stb      (stb)
  );

  fpwm_dp #(.CNT_W(CNT_W), .RES_LO(RES_LO)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .wrData   (wrData),
    .count    (count),
    .topVal   (topVal),
    .cmpAct   (cmpAct),
    .capIsTop (capIsTop),
    .topSel   (topSel),
    .chMode   (chMode),
    .flags    (flags),
    .pwm      (pwm)
  );

  assign pwmA = pwm[0];
  assign pwmB = pwm[1];

endmodule

// File: rtl/fpwm_chk.sv
module fpwm_chk
  import fpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [CNT_W-1:0]  wrData,
  input logic [CNT_W-1:0]  count,
  input logic [FLAG_N-1:0] flags,
  input logic              pwmA,
  input logic [2:0]        topSel,
  input logic [1:0]        modeA,
  input logic [CNT_W-1:0]  cmpAAct
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (count == '0) && (flags == '0) && !pwmA);

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));

  // R3
  ovf_restart_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[0]) |-> (count == '0) && $past(tick));

  // R4
  topa_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(flags[0]) && ($past(topSel) == 3'd3)) |-> flags[1]);

  // R5
  reload_at_top_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cmpAAct) |-> (count == '0) && $past(tick));

  // R11
  off_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !modeA[1] |=> !pwmA);

  // R12
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flags[0] && !(wrEn && (wrAddr == ADDR_W'(ADR_CLR)) && wrData[0])) |=> flags[0]);

endmodule

bind fpwm_timer fpwm_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .count   (count),
  .flags   (flags),
  .pwmA    (pwmA),
  .topSel  (topSel),
  .modeA   (chMode[0]),
  .cmpAAct (cmpAct[0])
);

// File: tb/sim_fpwm_timer.sv
`timescale 1ns/1ps
module sim_fpwm_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] count;
  logic [3:0]  flags;
  logic        pwmA;
  logic        pwmB;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fpwm_timer u0 (
    .clk(clk), .rst(rst), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .count(count), .flags(flags), .pwmA(pwmA), .pwmB(pwmB)
  );

  // sel, modeB, cmpB, cap, cmpA buffer, expected TOP, expected high ticks on pwmB
  localparam logic [84:0] VEC [8] = '{
    {3'd0, 2'd2, 16'h0040, 16'h0000, 16'h0000, 16'd255,  16'd65},   // R9
    {3'd1, 2'd3, 16'h0100, 16'h0000, 16'h0000, 16'd511,  16'd255},  // R10
    {3'd2, 2'd2, 16'h03FF, 16'h0000, 16'h0000, 16'd1023, 16'd1024}, // R9 cmp==TOP
    {3'd4, 2'd2, 16'h0010, 16'h0030, 16'h0000, 16'd48,   16'd17},   // R3 capture TOP
    {3'd4, 2'd2, 16'h0050, 16'h0020, 16'h0000, 16'd32,   16'd33},   // R7 cmp above TOP
    {3'd0, 2'd3, 16'h0105, 16'h0000, 16'h0000, 16'd255,  16'd250},  // R8 masking
    {3'd0, 2'd1, 16'h0040, 16'h0000, 16'h0000, 16'd255,  16'd0},    // R11
    {3'd3, 2'd2, 16'h0020, 16'h0000, 16'h0080, 16'd128,  16'd33}    // R3 compare A TOP
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; tick = 1'b0; wrEn = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCount(input logic [15:0] v);
    while (count !== v) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int high;
    doReset();
    // R1 reset state
    check("R1 count", int'(count), 0);
    check("R1 flags", int'(flags), 0);
    check("R1 pwm", int'({pwmA, pwmB}), 0);

    // R2 counter holds without tick, steps on each tick
    repeat (5) @(negedge clk);
    check("R2 hold", int'(count), 0);
    for (int i = 0; i < 3; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
    end
    check("R2 step", int'(count), 3);

    // R3 fixed 8-bit TOP restart with overflow flag, R12 set wins over clear
    tick = 1'b1;
    waitCount(16'd255);
    check("R3 pre-top flag", int'(flags[0]), 0);
    wrEn = 1'b1; wrAddr = 3'd4; wrData = 16'h0001;
    @(negedge clk);
    wrEn = 1'b0;
    check("R3 wrap count", int'(count), 0);
    check("R12 set wins", int'(flags[0]), 1);
    wr(3'd4, 16'h0001);
    check("R12 clear", int'(flags[0]), 0);

    // R1 mid-run reset
    repeat (10) @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R1 mid-run count", int'(count), 0);
    check("R1 mid-run flags", int'(flags), 0);

    // R4 compare A TOP sets both flags together; R12 selective clear
    doReset();
    wr(3'd0, 16'h0003);
    wr(3'd1, 16'h0020);
    tick = 1'b1;
    @(negedge clk);
    wr(3'd4, 16'h0001);
    check("R12 selective clear", int'(flags[1:0]), 2);
    wr(3'd4, 16'h000F);
    waitCount(16'h0020);
    check("R4 before top", int'(flags), 0);
    @(negedge clk);
    check("R4 A with ovf", int'(flags[1:0]), 3);

    // R5 double buffer for compare A
    doReset();
    wr(3'd0, 16'h0020);
    tick = 1'b1;
    waitCount(16'd5);
    wr(3'd1, 16'h0010);
    wr(3'd4, 16'h0002);
    waitCount(16'h0030);
    check("R5 buffer not active", int'(flags[1]), 0);
    waitCount(16'd255);
    @(negedge clk);
    high = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwmA) high++;
      @(negedge clk);
    end
    check("R5 new duty", high, 17);
    check("R5 match flag", int'(flags[1]), 1);

    // R6 capture TOP overtaken
    doReset();
    wr(3'd0, 16'h0004);
    wr(3'd3, 16'h0100);
    tick = 1'b1;
    waitCount(16'h0080);
    wr(3'd3, 16'h0040);
    wr(3'd4, 16'h000F);
    waitCount(16'hFFFF);
    check("R6 no ovf on run-on", int'(flags[0]), 0);
    @(negedge clk);
    check("R6 wrap to zero", int'(count), 0);
    check("R6 no ovf on wrap", int'({flags[3], flags[0]}), 0);
    waitCount(16'h0040);
    @(negedge clk);
    check("R6 restart", int'(count), 0);
    check("R4 capture flag with ovf", int'({flags[3], flags[0]}), 3);

    // R7 compare B match flag, and never above TOP
    doReset();
    wr(3'd0, 16'h0004);
    wr(3'd3, 16'h0020);
    wr(3'd2, 16'h0010);
    tick = 1'b1;
    waitCount(16'h0010);
    check("R7 before match", int'(flags[2]), 0);
    @(negedge clk);
    check("R7 match", int'(flags[2]), 1);
    wr(3'd2, 16'h0050);
    wr(3'd4, 16'h0004);
    repeat (100) @(negedge clk);
    check("R7 above top", int'(flags[2]), 0);

    // Vector table: TOP sources, modes and masking on pwmB
    for (int v = 0; v < 8; v++) begin
      doReset();
      wr(3'd0, {8'd0, VEC[v][81:80], 2'd0, 1'b0, VEC[v][84:82]});
      wr(3'd1, VEC[v][47:32]);
      wr(3'd2, VEC[v][79:64]);
      wr(3'd3, VEC[v][63:48]);
      tick = 1'b1;
      waitCount(VEC[v][31:16]);
      @(negedge clk);
      high = 0;
      for (int i = 0; i < int'(VEC[v][31:16]) + 1; i++) begin
        if (pwmB) high++;
        @(negedge clk);
      end
      check($sformatf("R9/R10 vector %0d period", v), int'(count), 0);
      check($sformatf("R8/R9/R10/R11 vector %0d duty", v), high, int'(VEC[v][15:0]));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule